// File: doc/BRIEF.md
# SPI Serial EEPROM Slave

This block is the device side of a serial byte-addressed memory reached over SPI in clock modes 0 and 3. A host selects the device by pulling the active-low select line, shifts in an 8-bit command, and then an address, data or a status byte depending on the command. The storage is an internal register array; its size is set by the `ADDR_W` parameter (4096 bytes by default). Writes to the array and to the status register need a prior write-enable command. Each completed write starts a fixed busy interval that stands in for the programming time. A write-protect pin together with a protect-enable status bit can lock the status register. A pause input lets the host suspend a transfer and continue it later without losing its place.

All pins are sampled by the system clock `clk` through two-flop synchronizers, and serial edges are detected from the sampled clock. The controller is a state machine with the states IDLE, OPCODE, RADDR, WADDR, RDATA, WDATA, STAT_OUT, STAT_IN and IGNORE. Select falling moves any state to OPCODE, and select rising moves any state to IDLE. After eight command bits, OPCODE goes to RADDR (read), WADDR (write with the latch set), STAT_OUT (status read), STAT_IN (status write with the latch set) or IGNORE (every other case). RADDR goes to RDATA and WADDR goes to WDATA after 16 address bits. RDATA, WDATA, STAT_OUT, STAT_IN and IGNORE hold until select rises.

Top module: `spi_eeprom_slave`

## Requirements
- R1: While `cs_n` is high, and after reset, `so_oe` is 0 and the block waits for the next falling edge of `cs_n`.
- R2: `si` is taken on rising `sck` edges and `so` changes only after falling `sck` edges, both with `sck` idling low (mode 0) and idling high (mode 3).
- R3: The first byte after `cs_n` falls is the command: 0x06 sets the write-enable latch, 0x04 clears it, 0x05 reads status, 0x01 writes status, 0x03 reads and 0x02 writes. Any other byte makes the block ignore the rest of that selection and keep `so_oe` at 0.
- R4: A read takes a 16-bit address, MSB first. Bits above `ADDR_W` are ignored. The addressed byte is then returned MSB first.
- R5: During a read, the address steps by one after each byte and wraps from the top address (0x0FFF by default) to 0. A write that runs past the top address wraps the same way.
- R6: A write command given while the write-enable latch is 0 leaves the array and the status unchanged.
- R7: A write that ends with `cs_n` rising on a byte boundary, after at least one data byte, clears the latch and sets the busy bit for `BUSY_CYCLES` clocks.
- R8: While busy, only the status read is answered. Every other command, including 0x06, is ignored.
- R9: The status byte carries busy in bit 0, the latch in bit 1 and protect-enable in bit 7; the other bits read 0. A status read returns a fresh status byte for each further byte clocked in the same selection.
- R10: A status write needs the latch. It changes only bit 7. When `wp_n` is low and bit 7 is 1, a status write has no effect at all: status, latch and busy stay as they were. When `wp_n` is high, the write takes effect.
- R11: Command 0x04 clears the write-enable latch.
- R12: While the pause input is active (`hold_n` is low, sampled while `sck` is low), `sck` and `si` are ignored, `so_oe` is 0, and the transfer resumes at the same bit when `hold_n` returns high with `sck` low.
- R13: A write cut off by `cs_n` rising in the middle of a data byte discards that byte. The latch stays set and no busy interval starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low device select |
| si | input | 1 | Serial data from the host |
| hold_n | input | 1 | Active-low pause request |
| wp_n | input | 1 | Active-low status write protect |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Output enable for `so` (0 means high impedance) |

## Verification
The hardest state to reach from the pins is a pause in the middle of an address or data byte, with serial clock edges arriving while paused. The bench stops after the first address byte, lowers `hold_n` with `sck` low, and toggles `sck` and `si` with garbage. It then releases the pause and finishes the address. Data comes back correct only if the bit position survived the pause. A second pause between two output bytes checks that the output is released and then resumes. The busy window is reached by issuing a read and a write-enable directly after a committed write, before the window closes.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_READ = 8'h03;
    localparam logic [7:0] OP_WRIT = 8'h02;

    typedef enum logic [3:0] {
        S_IDLE,
        S_OPCODE,
        S_RADDR,
        S_WADDR,
        S_RDATA,
        S_WDATA,
        S_STAT_OUT,
        S_STAT_IN,
        S_IGNORE
    } ee_state_t;

endpackage

// File: rtl/spi_ee_pins.sv
module spi_ee_pins (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic si,
    input  logic cs_n,
    input  logic hold_n,
    input  logic wp_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic si_s,
    output logic cs_start,
    output logic cs_end,
    output logic cs_idle,
    output logic hold_on,
    output logic wp_n_s
);
    // bit order: sck, si, cs_n, hold_n, wp_n
    localparam logic [4:0] PIN_RESET = 5'b00111;

    logic [4:0] meta_q, sync_q;
    logic       sck_p, cs_p, hold_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= PIN_RESET;
            sync_q <= PIN_RESET;
            sck_p  <= 1'b0;
            cs_p   <= 1'b1;
            hold_q <= 1'b0;
        end else begin
            meta_q <= {sck, si, cs_n, hold_n, wp_n};
            sync_q <= meta_q;
            sck_p  <= sync_q[4];
            cs_p   <= sync_q[2];
            if (sync_q[2])
                hold_q <= 1'b0;
            else if (!sync_q[4])
                hold_q <= !sync_q[1];
        end
    end

    assign sck_rise = sync_q[4] && !sck_p && !hold_q && !sync_q[2];
    assign sck_fall = !sync_q[4] && sck_p && !hold_q && !sync_q[2];
    assign si_s     = sync_q[3];
    assign cs_start = !sync_q[2] && cs_p;
    assign cs_end   = sync_q[2] && !cs_p;
    assign cs_idle  = sync_q[2];
    assign hold_on  = hold_q;
    assign wp_n_s   = sync_q[0];

endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/spi_ee_ctrl.sv
module spi_ee_ctrl
    import spi_ee_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int BUSY_CYCLES = 1500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              si,
    input  logic              cs_start,
    input  logic              cs_end,
    input  logic              hold_on,
    input  logic              wp_n,
    input  logic [7:0]        mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    output logic              so,
    output logic              so_oe
);
    localparam int BW   = $clog2(BUSY_CYCLES + 1);
    localparam int SH_W = (ADDR_W - 1 > 7) ? ADDR_W - 1 : 7;

    ee_state_t         state_q, state_d;
    logic [3:0]        bit_cnt;
    logic [SH_W-1:0]   sh;
    logic [ADDR_W-1:0] addr_q;
    logic              wel_q, wpen_q, pend_q, wr_any_q;
    logic [BW-1:0]     busy_cnt;
    logic              busy, op_done, addr_done, byte_in, out_state;
    logic              wr_commit, sr_commit, rd_step;
    logic [7:0]        op_in, status, src;
    logic [2:0]        out_cnt;
    logic [6:0]        out_sh;

    function automatic ee_state_t decode(input logic [7:0] op, input logic bsy,
                                         input logic we_en);
        if (bsy)
            return (op == OP_RDSR) ? S_STAT_OUT : S_IGNORE;
        case (op)
            OP_RDSR: return S_STAT_OUT;
            OP_READ: return S_RADDR;
            OP_WRIT: return we_en ? S_WADDR : S_IGNORE;
            OP_WRSR: return we_en ? S_STAT_IN : S_IGNORE;
            default: return S_IGNORE;
        endcase
    endfunction

    assign op_in     = {sh[6:0], si};
    assign busy      = (busy_cnt != '0);
    assign status    = {wpen_q, 5'b00000, wel_q, busy};
    assign op_done   = sck_rise && state_q == S_OPCODE && bit_cnt == 4'd7;
    assign addr_done = sck_rise && (state_q == S_RADDR || state_q == S_WADDR)
                       && bit_cnt == 4'd15;
    assign byte_in   = sck_rise && (state_q == S_WDATA || state_q == S_STAT_IN)
                       && bit_cnt == 4'd7;
    assign out_state = (state_q == S_RDATA) || (state_q == S_STAT_OUT);
    assign rd_step   = state_q == S_RDATA && sck_fall && out_cnt == 3'd7;
    assign wr_commit = cs_end && state_q == S_WDATA && bit_cnt == 4'd0 && wr_any_q;
    assign sr_commit = cs_end && state_q == S_STAT_IN && bit_cnt == 4'd0 && wr_any_q
                       && (wp_n || !wpen_q);

    // next state
    always_comb begin
        state_d = state_q;
        if (cs_start)
            state_d = S_OPCODE;
        else if (cs_end)
            state_d = S_IDLE;
        else if (sck_rise) begin
            unique case (state_q)
                S_OPCODE: if (bit_cnt == 4'd7) state_d = decode(op_in, busy, wel_q);
                S_RADDR:  if (bit_cnt == 4'd15) state_d = S_RDATA;
                S_WADDR:  if (bit_cnt == 4'd15) state_d = S_WDATA;
                S_IDLE, S_RDATA, S_WDATA, S_STAT_OUT, S_STAT_IN, S_IGNORE:
                    state_d = state_q;
            endcase
        end
    end

    assign mem_we    = byte_in && state_q == S_WDATA;
    assign mem_wdata = op_in;
    assign mem_addr  = addr_q;

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            bit_cnt  <= '0;
            sh       <= '0;
            addr_q   <= '0;
            wel_q    <= 1'b0;
            wpen_q   <= 1'b0;
            pend_q   <= 1'b0;
            wr_any_q <= 1'b0;
            busy_cnt <= '0;
        end else begin
            state_q <= state_d;
            if (cs_start) begin
                bit_cnt  <= '0;
                wr_any_q <= 1'b0;
            end else if (sck_rise) begin
                sh <= {sh[SH_W-2:0], si};
                if (state_d != state_q || byte_in)
                    bit_cnt <= '0;
                else
                    bit_cnt <= bit_cnt + 4'd1;
                if (byte_in) begin
                    wr_any_q <= 1'b1;
                    if (state_q == S_STAT_IN)
                        pend_q <= sh[6];
                end
            end
            if (op_done && !busy) begin
                if (op_in == OP_WREN) wel_q <= 1'b1;
                if (op_in == OP_WRDI) wel_q <= 1'b0;
            end
            if (addr_done)
                addr_q <= {sh[ADDR_W-2:0], si};
            else if (mem_we || rd_step)
                addr_q <= addr_q + 1'b1;
            if (wr_commit || sr_commit) begin
                busy_cnt <= BW'(BUSY_CYCLES);
                wel_q    <= 1'b0;
            end else if (busy)
                busy_cnt <= busy_cnt - 1'b1;
            if (sr_commit)
                wpen_q <= pend_q;
        end
    end

    // serial output
    assign src = (state_q == S_RDATA) ? mem_rdata : status;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            so      <= 1'b0;
            out_cnt <= '0;
            out_sh  <= '0;
        end else if (cs_start) begin
            out_cnt <= '0;
        end else if (sck_fall && out_state) begin
            if (out_cnt == 3'd0) begin
                so     <= src[7];
                out_sh <= src[6:0];
            end else begin
                so     <= out_sh[6];
                out_sh <= {out_sh[5:0], 1'b0};
            end
            out_cnt <= out_cnt + 3'd1;
        end
    end

    assign so_oe = out_state && !hold_on;

    p_wr_needs_wel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (wel_q && !busy));

    p_busy_decode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && busy && !cs_end && !cs_start)
        |=> (state_q == S_STAT_OUT || state_q == S_IGNORE));

    p_wpen_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_n && wpen_q) |=> wpen_q);

    p_hold_freeze_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_on && !cs_end) |=> $stable(bit_cnt));

    p_commit_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> (!wel_q && busy));

endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
    parameter int ADDR_W      = 12,
    parameter int BUSY_CYCLES = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    input  logic hold_n,
    input  logic wp_n,
    output logic so,
    output logic so_oe
);
    logic              sck_rise, sck_fall, si_s, cs_start, cs_end, cs_idle;
    logic              hold_on, wp_n_s, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata, mem_rdata;

    spi_ee_pins u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .si       (si),
        .cs_n     (cs_n),
        .hold_n   (hold_n),
        .wp_n     (wp_n),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .si_s     (si_s),
        .cs_start (cs_start),
        .cs_end   (cs_end),
        .cs_idle  (cs_idle),
        .hold_on  (hold_on),
        .wp_n_s   (wp_n_s)
    );

    spi_ee_ctrl #(
        .ADDR_W      (ADDR_W),
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .si        (si_s),
        .cs_start  (cs_start),
        .cs_end    (cs_end),
        .hold_on   (hold_on),
        .wp_n      (wp_n_s),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .so        (so),
        .so_oe     (so_oe)
    );

    spi_ee_array #(
        .ADDR_W (ADDR_W)
    ) u_array (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    p_idle_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_idle && $past(cs_idle)) |-> !so_oe);

endmodule

// File: tb/test_spi_eeprom_slave.sv
module test_spi_eeprom_slave;
    localparam int HP   = 6;
    localparam int BUSY = 1500;
    localparam int AW   = 12;
    localparam logic [15:0] TOP = 16'h0FFF;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
    logic so, so_oe;
    int   checks = 0, errors = 0, r2_err = 0;
    bit   mode3 = 1'b0, done = 1'b0;

    always #5 clk = ~clk;

    spi_eeprom_slave #(.ADDR_W(AW), .BUSY_CYCLES(BUSY)) i_spi_eeprom_slave (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe));

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer_n(input logic [7:0] tx, input int nb,
                          output logic [7:0] rx, output logic oe);
        oe = 1'b0;
        rx = 8'h00;
        for (int i = 7; i > 7 - nb; i--) begin
            logic pre, pre_oe;
            if (mode3) sck = 1'b0;
            si = tx[i];
            wait_clk(HP);
            rx[i] = so; pre = so; pre_oe = so_oe; oe |= so_oe;
            sck = 1'b1;
            wait_clk(HP);
            if (pre_oe && so_oe && so !== pre) r2_err++;
            if (!mode3) sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output logic oe);
        xfer_n(tx, 8, rx, oe);
    endtask

    task automatic cs_on();
        sck = mode3;
        wait_clk(HP);
        cs_n = 1'b0;
        wait_clk(HP);
    endtask

    task automatic cs_off();
        wait_clk(HP);
        cs_n = 1'b1;
        wait_clk(2 * HP);
    endtask

    task automatic send1(input logic [7:0] op);
        logic [7:0] rx; logic oe;
        cs_on(); xfer(op, rx, oe); cs_off();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] rx; logic oe;
        cs_on(); xfer(8'h05, rx, oe); xfer(8'h00, s, oe); cs_off();
    endtask

    task automatic write2(input logic [15:0] a, input logic [7:0] d0, input logic [7:0] d1,
                          input bit en);
        logic [7:0] rx; logic oe;
        if (en) send1(8'h06);
        cs_on();
        xfer(8'h02, rx, oe); xfer(a[15:8], rx, oe); xfer(a[7:0], rx, oe);
        xfer(d0, rx, oe); xfer(d1, rx, oe);
        cs_off();
    endtask

    task automatic read2(input logic [15:0] a, output logic [7:0] r0, output logic [7:0] r1,
                         output logic oe_any);
        logic [7:0] rx; logic oe;
        cs_on();
        xfer(8'h03, rx, oe); oe_any = oe;
        xfer(a[15:8], rx, oe); oe_any |= oe;
        xfer(a[7:0], rx, oe);  oe_any |= oe;
        xfer(8'h00, r0, oe);   oe_any |= oe;
        xfer(8'h00, r1, oe);   oe_any |= oe;
        cs_off();
    endtask

    task automatic wait_busy();
        wait_clk(BUSY + 20);
    endtask

    task automatic t_reset();
        logic [7:0] s;
        chk("R1 so_oe after reset", {15'd0, so_oe}, 16'd0);
        rdsr(s);
        chk("R9 status after reset", {8'd0, s}, 16'h0000);
    endtask

    task automatic t_latch();
        logic [7:0] s, s1, s2, rx; logic oe;
        send1(8'h06);
        rdsr(s);
        chk("R3 enable sets latch bit", {8'd0, s}, 16'h0002);
        cs_on(); xfer(8'h05, rx, oe); xfer(8'h00, s1, oe); xfer(8'h00, s2, oe); cs_off();
        chk("R9 repeated status byte 1", {8'd0, s1}, 16'h0002);
        chk("R9 repeated status byte 2", {8'd0, s2}, 16'h0002);
        send1(8'h04);
        rdsr(s);
        chk("R11 disable clears latch", {8'd0, s}, 16'h0000);
    endtask

    task automatic t_write_read();
        logic [7:0] s, r0, r1; logic oe;
        write2(16'h0010, 8'hA5, 8'h3C, 1'b1);
        chk("R1 so_oe after deselect", {15'd0, so_oe}, 16'd0);
        rdsr(s);
        chk("R7 busy set, latch cleared", {8'd0, s}, 16'h0001);
        wait_busy();
        rdsr(s);
        chk("R7 busy ends", {8'd0, s}, 16'h0000);
        read2(16'hE010, r0, r1, oe);
        chk("R4 read byte 0 upper bits ignored", {8'd0, r0}, 16'h00A5);
        chk("R5 read byte 1 sequential", {8'd0, r1}, 16'h003C);
        chk("R2 mode 0 so stable across rise", r2_err[15:0], 16'd0);
    endtask

    task automatic t_no_latch();
        logic [7:0] s, r0, r1; logic oe;
        write2(16'h0010, 8'hFF, 8'hFF, 1'b0);
        rdsr(s);
        chk("R6 no busy without latch", {8'd0, s}, 16'h0000);
        read2(16'h0010, r0, r1, oe);
        chk("R6 array byte 0 unchanged", {8'd0, r0}, 16'h00A5);
        chk("R6 array byte 1 unchanged", {8'd0, r1}, 16'h003C);
    endtask

    task automatic t_busy();
        logic [7:0] s, r0, r1; logic oe;
        write2(16'h0020, 8'h5A, 8'hC3, 1'b1);
        read2(16'h0010, r0, r1, oe);
        chk("R8 read ignored while busy (so_oe)", {15'd0, oe}, 16'd0);
        send1(8'h06);
        wait_busy();
        rdsr(s);
        chk("R8 enable ignored while busy", {8'd0, s}, 16'h0000);
        read2(16'h0020, r0, r1, oe);
        chk("R7 committed write byte 0", {8'd0, r0}, 16'h005A);
        chk("R7 committed write byte 1", {8'd0, r1}, 16'h00C3);
    endtask

    task automatic t_wrap();
        logic [7:0] r0, r1; logic oe;
        write2(TOP, 8'h11, 8'h22, 1'b1);
        wait_busy();
        read2(TOP, r0, r1, oe);
        chk("R5 top address byte", {8'd0, r0}, 16'h0011);
        chk("R5 wrapped byte", {8'd0, r1}, 16'h0022);
        read2(16'h0000, r0, r1, oe);
        chk("R5 write wrapped to address 0", {8'd0, r0}, 16'h0022);
    endtask

    task automatic t_bad_op();
        logic [7:0] s, rx; logic oe, oe2;
        cs_on();
        xfer(8'hFF, rx, oe); xfer(8'h05, rx, oe2); oe |= oe2; xfer(8'h06, rx, oe2); oe |= oe2;
        cs_off();
        chk("R3 unknown opcode keeps so_oe low", {15'd0, oe}, 16'd0);
        rdsr(s);
        chk("R3 later bytes after unknown opcode ignored", {8'd0, s}, 16'h0000);
    endtask

    task automatic t_status_write();
        logic [7:0] s, rx; logic oe;
        send1(8'h06);
        cs_on(); xfer(8'h01, rx, oe); xfer(8'hFF, rx, oe); cs_off();
        wait_busy();
        rdsr(s);
        chk("R10 only bit 7 written", {8'd0, s}, 16'h0080);
        wp_n = 1'b0;
        send1(8'h06);
        cs_on(); xfer(8'h01, rx, oe); xfer(8'h00, rx, oe); cs_off();
        wait_clk(4 * HP);
        rdsr(s);
        chk("R10 locked write has no effect", {8'd0, s}, 16'h0082);
        wp_n = 1'b1;
        cs_on(); xfer(8'h01, rx, oe); xfer(8'h00, rx, oe); cs_off();
        wait_busy();
        rdsr(s);
        chk("R10 unlocked write clears bit 7", {8'd0, s}, 16'h0000);
        cs_on(); xfer(8'h01, rx, oe); xfer(8'h80, rx, oe); cs_off();
        wait_clk(4 * HP);
        rdsr(s);
        chk("R10 status write needs latch", {8'd0, s}, 16'h0000);
    endtask

    task automatic t_partial();
        logic [7:0] s, r0, r1, rx; logic oe;
        send1(8'h06);
        cs_on();
        xfer(8'h02, rx, oe); xfer(8'h00, rx, oe); xfer(8'h10, rx, oe);
        xfer_n(8'h00, 4, rx, oe);
        cs_off();
        rdsr(s);
        chk("R13 latch kept, no busy", {8'd0, s}, 16'h0002);
        read2(16'h0010, r0, r1, oe);
        chk("R13 partial byte discarded", {8'd0, r0}, 16'h00A5);
        send1(8'h04);
    endtask

    task automatic t_mode3();
        logic [7:0] s, r0, r1; logic oe;
        mode3 = 1'b1;
        write2(16'h0040, 8'h96, 8'h69, 1'b1);
        wait_busy();
        read2(16'h0040, r0, r1, oe);
        chk("R2 mode 3 byte 0", {8'd0, r0}, 16'h0096);
        chk("R2 mode 3 byte 1", {8'd0, r1}, 16'h0069);
        rdsr(s);
        chk("R2 mode 3 status", {8'd0, s}, 16'h0000);
        mode3 = 1'b0;
        chk("R2 so stable across rise, both modes", r2_err[15:0], 16'd0);
    endtask

    task automatic t_hold();
        logic [7:0] r0, r1, rx; logic oe;
        cs_on();
        xfer(8'h03, rx, oe); xfer(8'h00, rx, oe);
        hold_n = 1'b0;
        wait_clk(HP);
        chk("R12 so_oe low while paused in address", {15'd0, so_oe}, 16'd0);
        repeat (3) begin
            sck = 1'b1; si = ~si; wait_clk(HP);
            sck = 1'b0; wait_clk(HP);
        end
        hold_n = 1'b1;
        wait_clk(HP);
        xfer(8'h10, rx, oe);
        xfer(8'h00, r0, oe);
        chk("R12 address kept across pause", {8'd0, r0}, 16'h00A5);
        hold_n = 1'b0;
        wait_clk(HP);
        chk("R12 so_oe low while paused in data", {15'd0, so_oe}, 16'd0);
        hold_n = 1'b1;
        wait_clk(HP);
        xfer(8'h00, r1, oe);
        chk("R12 output resumes after pause", {8'd0, r1}, 16'h003C);
        cs_off();
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_latch();
        t_write_read();
        t_no_latch();
        t_busy();
        t_wrap();
        t_bad_op();
        t_status_write();
        t_partial();
        t_mode3();
        t_hold();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_clk(190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 run: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule